// File: doc/BRIEF.md
# Block Register Transfer Sequencer

This block carries out one multi-register transfer. It moves a set of registers from a 16-entry register file to consecutive memory words, or fills them from consecutive memory words. A one-cycle `start` pulse hands it four things: a 16-bit register mask, the index of the register that holds the start address, a load/store select and a write-back enable. The block then reads the start address and walks the mask from the lowest register number to the highest. On each transfer it drives a word address together with a read or write strobe. Load data goes back into the register file through a single write port.

Each busy cycle carries a cycle-type tag: non-sequential, sequential or internal. Counting the tags gives the timing cost of the instruction. A memory-side fault input is sampled on every transfer. A store with a fault still completes every transfer. A load with a fault stops updating registers from the faulting transfer onward, then puts the address register back in a known state. In both cases a trap request is raised when the instruction ends and stays up until it is acknowledged.

Top module: `lsm_seq`

## Requirements
- R1: While reset is asserted and after it, `busy`, `done`, `mem_rd`, `mem_wr`, `rf_we` and `trap_req` are all low.
- R2: The k-th transfer (k from 0) moves the k-th lowest register in the mask, at word address base+4k. `mem_rd` and `mem_wr` are never high together. On a load, each transfer's word ends up in its register.
- R3: When write-back is enabled, the address register is set to base+4n, where n is the number of registers in the mask, at the end of the second busy cycle. When write-back is disabled, the address register is not changed by a store.
- R4: On a store, if the address register is the first register in the mask, its original value is written to memory. If it comes later and write-back is enabled, the value base+4n is written.
- R5: On a load whose mask contains the address register, the loaded word is its final value. The loaded word wins over the write-back value.
- R6: On a store with a fault on any transfer, every transfer still takes place. Only the write-back changes the register file. `trap_req` rises in the cycle after `done`.
- R7: On a load with a fault, the faulting transfer and all later transfers leave their registers unchanged. Earlier transfers keep their loaded values.
- R8: After a load with a fault, the address register holds base+4n if write-back was enabled, or the original base otherwise. This holds even if a loaded word had replaced it.
- R9: Register 15 is always transferred last. After a load with a fault, register 15 keeps its prior value and the two refill cycles are skipped.
- R10: `cyc_type` is 2'b00 for non-sequential, 2'b01 for sequential and 2'b10 for internal. No bus strobe is high in an internal cycle. A load of n registers without register 15 takes n sequential, 1 non-sequential and 1 internal cycle.
- R11: A load of n registers that includes register 15, without a fault, takes n+1 sequential, 2 non-sequential and 1 internal cycle.
- R12: A store of n registers takes n-1 sequential and 2 non-sequential cycles.
- R13: An empty mask takes a single busy cycle. That cycle is internal, has `done` high and has no bus strobe.
- R14: `done` is high for exactly the last busy cycle. `trap_req` stays high until a cycle with `trap_ack` high. A `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction (accepted only when idle) |
| start_list | input | 16 | Register mask, bit i selects register i |
| start_base | input | 4 | Index of the address register |
| start_load | input | 1 | 1 = load from memory, 0 = store to memory |
| start_wb | input | 1 | Write the updated address back |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Last cycle of the instruction |
| cyc_type | output | 2 | Cycle tag: 00 non-sequential, 01 sequential, 10 internal |
| rf_raddr | output | 4 | Register file read index |
| rf_rdata | input | 32 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 4 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| mem_addr | output | 32 | Memory byte address of the transfer |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_rd` |
| mem_abort | input | 1 | Fault on the current transfer |
| trap_req | output | 1 | Data-fault trap request |
| trap_ack | input | 1 | Clears `trap_req` |

## Verification
The assertions check several properties on every cycle. The read and write strobes never overlap, and consecutive transfers step the address by one word. Internal cycles carry no strobe. `done` lasts one cycle and appears only while busy. A trap request rises only after `done` and stays up until acknowledged. Other behaviour needs whole scenarios and only the bench can show it: which value a store of the address register writes, load data beating write-back, register restoration after a load fault, and the per-type cycle totals for each kind of instruction.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    typedef enum logic [1:0] {
        CYC_N = 2'b00,
        CYC_S = 2'b01,
        CYC_I = 2'b10
    } cyc_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EMPTY,
        ST_SETUP,
        ST_XFER,
        ST_TAIL,
        ST_REFN,
        ST_REFS
    } seq_st_t;

endpackage

// File: rtl/lsm_lowest_set.sv
module lsm_lowest_set #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);
    logic [N-1:0] found;

    // found[i]: some bit at or below i is set
    generate
        for (genvar i = 0; i < N; i++) begin : g_scan
            if (i == 0) begin : g_first
                assign found[i] = vec[i];
            end else begin : g_rest
                assign found[i] = found[i-1] | vec[i];
            end
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end

    assign any = found[N-1];
endmodule

// File: rtl/lsm_popcount.sv
module lsm_popcount #(
    parameter int N  = 16,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  vec,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = '0;
        for (int i = 0; i < N; i++) begin
            cnt = cnt + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/lsm_rf_wport.sv
module lsm_rf_wport #(
    parameter int DW = 32,
    parameter int IW = 4
) (
    input  logic          wb_fire,
    input  logic [IW-1:0] wb_idx,
    input  logic [DW-1:0] wb_val,
    input  logic          ld_fire,
    input  logic [IW-1:0] ld_idx,
    input  logic [DW-1:0] ld_val,
    input  logic          rs_fire,
    input  logic [IW-1:0] rs_idx,
    input  logic [DW-1:0] rs_val,
    output logic          we,
    output logic [IW-1:0] waddr,
    output logic [DW-1:0] wdata
);
    // restore beats load data, load data beats write-back
    always_comb begin
        we    = 1'b0;
        waddr = '0;
        wdata = '0;
        if (rs_fire) begin
            we    = 1'b1;
            waddr = rs_idx;
            wdata = rs_val;
        end else if (ld_fire) begin
            we    = 1'b1;
            waddr = ld_idx;
            wdata = ld_val;
        end else if (wb_fire) begin
            we    = 1'b1;
            waddr = wb_idx;
            wdata = wb_val;
        end
    end
endmodule

// File: rtl/lsm_seq.sv
module lsm_seq
    import lsm_pkg::*;
#(
    parameter int NREG       = 16,
    parameter int AW         = 32,
    parameter int WORD_BYTES = 4,
    localparam int IW        = $clog2(NREG),
    localparam int CW        = $clog2(NREG + 1),
    localparam int PC_IDX    = NREG - 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [NREG-1:0] start_list,
    input  logic [IW-1:0]   start_base,
    input  logic            start_load,
    input  logic            start_wb,
    output logic            busy,
    output logic            done,
    output logic [1:0]      cyc_type,
    output logic [IW-1:0]   rf_raddr,
    input  logic [AW-1:0]   rf_rdata,
    output logic            rf_we,
    output logic [IW-1:0]   rf_waddr,
    output logic [AW-1:0]   rf_wdata,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic [AW-1:0]   mem_wdata,
    input  logic [AW-1:0]   mem_rdata,
    input  logic            mem_abort,
    output logic            trap_req,
    input  logic            trap_ack
);

    typedef struct packed {
        seq_st_t         st;
        logic [NREG-1:0] left;
        logic [IW-1:0]   base_idx;
        logic            is_load;
        logic            wb_en;
        logic            has_pc;
        logic [AW-1:0]   base_val;
        logic [AW-1:0]   wb_val;
        logic [AW-1:0]   addr;
        logic            first;
        logic            faulted;
        logic            ld_valid;
        logic [IW-1:0]   ld_idx;
        logic [AW-1:0]   ld_data;
        logic            trap;
    } seq_t;

    seq_t q, d;

    logic [IW-1:0] cur_idx;
    logic          cur_any;
    logic [CW-1:0] n_regs;
    logic          wb_fire, ld_fire, rs_fire;
    logic [AW-1:0] rs_val;
    logic          trap_set;
    cyc_t          cyc;

    lsm_lowest_set #(.N(NREG), .IW(IW)) u_pick (
        .vec (q.left),
        .idx (cur_idx),
        .any (cur_any)
    );

    lsm_popcount #(.N(NREG), .CW(CW)) u_count (
        .vec (q.left),
        .cnt (n_regs)
    );

    lsm_rf_wport #(.DW(AW), .IW(IW)) u_wport (
        .wb_fire (wb_fire),
        .wb_idx  (q.base_idx),
        .wb_val  (q.wb_val),
        .ld_fire (ld_fire),
        .ld_idx  (q.ld_idx),
        .ld_val  (q.ld_data),
        .rs_fire (rs_fire),
        .rs_idx  (q.base_idx),
        .rs_val  (rs_val),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata)
    );

    assign rs_val = q.wb_en ? q.wb_val : q.base_val;

    always_comb begin
        d         = q;
        busy      = 1'b0;
        done      = 1'b0;
        cyc       = CYC_I;
        rf_raddr  = q.base_idx;
        mem_addr  = q.addr;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_wdata = '0;
        wb_fire   = 1'b0;
        ld_fire   = 1'b0;
        rs_fire   = 1'b0;
        trap_set  = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.left     = start_list;
                    d.base_idx = start_base;
                    d.is_load  = start_load;
                    d.wb_en    = start_wb;
                    d.has_pc   = start_list[PC_IDX];
                    d.first    = 1'b1;
                    d.faulted  = 1'b0;
                    d.ld_valid = 1'b0;
                    d.st       = (start_list == '0) ? ST_EMPTY : ST_SETUP;
                end
            end

            ST_EMPTY: begin
                busy = 1'b1;
                done = 1'b1;
                cyc  = CYC_I;
                d.st = ST_IDLE;
            end

            ST_SETUP: begin
                busy       = 1'b1;
                cyc        = CYC_N;
                d.base_val = rf_rdata;
                d.addr     = rf_rdata;
                d.wb_val   = rf_rdata + AW'(n_regs) * AW'(WORD_BYTES);
                d.st       = ST_XFER;
            end

            ST_XFER: begin
                busy     = 1'b1;
                rf_raddr = cur_idx;
                mem_rd   = q.is_load;
                mem_wr   = !q.is_load;
                if (!q.is_load) mem_wdata = rf_rdata;
                cyc      = (!q.is_load && q.first) ? CYC_N : CYC_S;
                // write-back commits at the end of the second busy cycle
                wb_fire  = q.first && q.wb_en;
                ld_fire  = q.ld_valid;
                d.first  = 1'b0;
                d.left   = q.left & ~(NREG'(1) << cur_idx);
                d.addr   = q.addr + AW'(WORD_BYTES);
                d.faulted = q.faulted | mem_abort;
                if (q.is_load) begin
                    d.ld_valid = !(q.faulted || mem_abort);
                    d.ld_idx   = cur_idx;
                    d.ld_data  = mem_rdata;
                end else begin
                    d.ld_valid = 1'b0;
                end
                if (d.left == '0) begin
                    if (q.is_load) begin
                        d.st = ST_TAIL;
                    end else begin
                        done     = 1'b1;
                        trap_set = d.faulted;
                        d.st     = ST_IDLE;
                    end
                end
            end

            ST_TAIL: begin
                busy       = 1'b1;
                cyc        = CYC_I;
                rs_fire    = q.faulted;
                ld_fire    = q.ld_valid && !q.faulted;
                d.ld_valid = 1'b0;
                if (q.faulted || !q.has_pc) begin
                    done     = 1'b1;
                    trap_set = q.faulted;
                    d.st     = ST_IDLE;
                end else begin
                    d.st = ST_REFN;
                end
            end

            ST_REFN: begin
                busy = 1'b1;
                cyc  = CYC_N;
                d.st = ST_REFS;
            end

            ST_REFS: begin
                busy = 1'b1;
                done = 1'b1;
                cyc  = CYC_S;
                d.st = ST_IDLE;
            end

            default: d.st = ST_IDLE;
        endcase

        d.trap = trap_set | (q.trap & ~trap_ack);
    end

    assign cyc_type = cyc;
    assign trap_req = q.trap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q          <= '0;
            q.st       <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    // cur_any is implied by the state machine never entering ST_XFER empty
    logic unused_any;
    assign unused_any = cur_any;

endmodule

// File: rtl/lsm_seq_chk.sv
module lsm_seq_chk
    import lsm_pkg::*;
#(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic [1:0]    cyc_type,
    input logic          rf_we,
    input logic [AW-1:0] mem_addr,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          trap_req,
    input logic          trap_ack
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr && !rf_we && !done)); // R1

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R2

    AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + AW'(4))); // R2

    AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && $past(mem_wr)) |-> (mem_addr == $past(mem_addr) + AW'(4))); // R2

    AST_INT_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_type == CYC_I) |-> (!mem_rd && !mem_wr)); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R14

    AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R14

    AST_TRAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !trap_ack) |=> trap_req); // R14

    AST_TRAP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trap_req) |-> $past(done)); // R6

endmodule

bind lsm_seq lsm_seq_chk #(.AW(AW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .cyc_type (cyc_type),
    .rf_we    (rf_we),
    .mem_addr (mem_addr),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .trap_req (trap_req),
    .trap_ack (trap_ack)
);

// File: tb/lsm_seq_tb.sv
`timescale 1ns/1ps
module lsm_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] start_list = '0;
    logic [3:0]  start_base = '0;
    logic        start_load = 1'b0;
    logic        start_wb = 1'b0;
    logic        busy, done;
    logic [1:0]  cyc_type;
    logic [3:0]  rf_raddr, rf_waddr;
    logic [31:0] rf_rdata, rf_wdata;
    logic        rf_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_rd, mem_wr, mem_abort;
    logic        trap_req;
    logic        trap_ack = 1'b0;

    always #2.5 clk = ~clk;

    lsm_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .start_list(start_list),
        .start_base(start_base), .start_load(start_load), .start_wb(start_wb),
        .busy(busy), .done(done), .cyc_type(cyc_type),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_abort(mem_abort),
        .trap_req(trap_req), .trap_ack(trap_ack)
    );

    // ---------------- environment models ----------------
    function automatic logic [31:0] init_val(input int r);
        return 32'h100 * (r + 1);
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a * 32'd7) ^ 32'h5A5A_0000;
    endfunction

    logic [31:0] rf [16];
    logic        rf_init = 1'b0;
    logic        ab_active = 1'b0;
    logic [31:0] ab_addr = '0;

    always @(posedge clk) begin
        if (rf_init) begin
            for (int i = 0; i < 16; i++) rf[i] <= init_val(i);
        end else if (rf_we) begin
            rf[rf_waddr] <= rf_wdata;
        end
    end

    assign rf_rdata  = rf[rf_raddr];
    assign mem_rdata = mem_word(mem_addr);
    assign mem_abort = ab_active && (mem_rd || mem_wr) && (mem_addr == ab_addr);

    // ---------------- monitor ----------------
    int n_cnt, s_cnt, i_cnt, strobes, dones, st_cnt;
    logic [31:0] st_addr [16];
    logic [31:0] st_data [16];

    always @(posedge clk) begin
        #1;
        if (rf_init) begin
            n_cnt = 0; s_cnt = 0; i_cnt = 0; strobes = 0; dones = 0; st_cnt = 0;
        end else if (busy) begin
            if (cyc_type == 2'b00) n_cnt++;
            else if (cyc_type == 2'b01) s_cnt++;
            else if (cyc_type == 2'b10) i_cnt++;
            if (mem_rd || mem_wr) strobes++;
            if (done) dones++;
            if (mem_wr && st_cnt < 16) begin
                st_addr[st_cnt] = mem_addr;
                st_data[st_cnt] = mem_wdata;
                st_cnt++;
            end
        end
    end

    // ---------------- checking ----------------
    int tests = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    typedef struct packed {
        logic [15:0] list;
        logic [3:0]  base;
        logic        ld;
        logic        wb;
        logic        ab_en;
        logic [3:0]  ab_k;
        logic        poke;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{16'h00F4, 4'd2, 1'b0, 1'b1, 1'b0, 4'd0, 1'b0},  // R4 base first
        '{16'h0036, 4'd5, 1'b0, 1'b1, 1'b0, 4'd0, 1'b0},  // R4 base later
        '{16'h8109, 4'd3, 1'b0, 1'b0, 1'b1, 4'd1, 1'b0},  // R6 store fault
        '{16'h00F0, 4'd1, 1'b1, 1'b1, 1'b0, 4'd0, 1'b1},  // R2 R3 R10 R14
        '{16'h0032, 4'd4, 1'b1, 1'b1, 1'b0, 4'd0, 1'b0},  // R5
        '{16'h80E0, 4'd0, 1'b1, 1'b0, 1'b0, 4'd0, 1'b0},  // R11
        '{16'h800E, 4'd2, 1'b1, 1'b1, 1'b1, 4'd2, 1'b0},  // R7 R8 R9
        '{16'h00C1, 4'd6, 1'b1, 1'b0, 1'b1, 4'd0, 1'b0}   // R8 no write-back
    };

    logic [31:0] exp_rf [16];
    logic [31:0] exp_sa [16];
    logic [31:0] exp_sd [16];

    task automatic wait_done();
        int g = 0;
        while (!done && g < 200) begin
            @(negedge clk);
            g++;
        end
    endtask

    task automatic run_vec(input vec_t v);
        int n = 0;
        int k = 0;
        int en, es, ei;
        logic [31:0] base0, wbv;
        for (int r = 0; r < 16; r++) exp_rf[r] = init_val(r);
        base0 = init_val(int'(v.base));
        for (int r = 0; r < 16; r++) if (v.list[r]) n++;
        wbv = base0 + 32'(4 * n);
        if (v.wb) exp_rf[v.base] = wbv;
        for (int r = 0; r < 16; r++) begin
            if (v.list[r]) begin
                exp_sa[k] = base0 + 32'(4 * k);
                if (!v.ld) begin
                    if (r == int'(v.base))
                        exp_sd[k] = (k == 0 || !v.wb) ? base0 : wbv;
                    else
                        exp_sd[k] = init_val(r);
                end else if (!v.ab_en || k < int'(v.ab_k)) begin
                    exp_rf[r] = mem_word(exp_sa[k]);
                end
                k++;
            end
        end
        if (v.ld && v.ab_en) exp_rf[v.base] = v.wb ? wbv : base0;
        if (!v.ld) begin en = 2; es = n - 1; ei = 0; end
        else if (v.list[15] && !v.ab_en) begin en = 2; es = n + 1; ei = 1; end
        else begin en = 1; es = n; ei = 1; end

        @(negedge clk); rf_init = 1'b1;
        @(negedge clk); rf_init = 1'b0;
        ab_active = v.ab_en;
        ab_addr   = base0 + 32'(4 * int'(v.ab_k));
        start = 1'b1; start_list = v.list; start_base = v.base;
        start_load = v.ld; start_wb = v.wb;
        @(negedge clk); start = 1'b0;
        if (v.poke) begin
            @(negedge clk); start = 1'b1; start_list = 16'hFFFF; start_load = 1'b0;
            @(negedge clk); start = 1'b0;
        end
        wait_done();
        @(negedge clk);
        ab_active = 1'b0;

        for (int r = 0; r < 16; r++)
            chk(rf[r] === exp_rf[r], v.ld ? "R2/R5/R7/R8/R9" : "R3/R6",
                $sformatf("rf[%0d]", r), rf[r], exp_rf[r]);
        if (!v.ld) begin
            chk(st_cnt == n, "R6", "store count", 32'(st_cnt), 32'(n));
            for (int j = 0; j < n && j < st_cnt; j++) begin
                chk(st_addr[j] === exp_sa[j], "R2", "store addr", st_addr[j], exp_sa[j]);
                chk(st_data[j] === exp_sd[j], "R4", "store data", st_data[j], exp_sd[j]);
            end
        end
        chk(n_cnt == en, v.ld ? "R10/R11" : "R12", "N cycles", 32'(n_cnt), 32'(en));
        chk(s_cnt == es, v.ld ? "R10/R11" : "R12", "S cycles", 32'(s_cnt), 32'(es));
        chk(i_cnt == ei, v.ld ? "R10/R11" : "R12", "I cycles", 32'(i_cnt), 32'(ei));
        chk(dones == 1, "R14", "done pulses", 32'(dones), 32'd1);
        chk(trap_req === v.ab_en, "R6", "trap after done", 32'(trap_req), 32'(v.ab_en));
        if (v.poke) begin
            repeat (2) @(negedge clk);
            chk(busy === 1'b0, "R14", "start while busy ignored", 32'(busy), 32'd0);
        end
        if (v.ab_en) begin
            repeat (2) @(negedge clk);
            chk(trap_req === 1'b1, "R14", "trap held", 32'(trap_req), 32'd1);
            trap_ack = 1'b1;
            @(negedge clk); trap_ack = 1'b0;
            @(negedge clk);
            chk(trap_req === 1'b0, "R14", "trap cleared", 32'(trap_req), 32'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_rd && !mem_wr && !rf_we && !trap_req, "R1",
            "outputs in reset", {26'd0, busy, done, mem_rd, mem_wr, rf_we, trap_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !trap_req, "R1", "outputs after reset",
            {30'd0, busy, trap_req}, 32'd0);

        for (int v = 0; v < NV; v++) run_vec(VECS[v]);

        // R13: empty mask
        @(negedge clk); rf_init = 1'b1;
        @(negedge clk); rf_init = 1'b0;
        start = 1'b1; start_list = 16'h0000; start_base = 4'd3; start_load = 1'b1; start_wb = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(done === 1'b1 && cyc_type === 2'b10, "R13", "empty done/internal",
            {30'd0, done, cyc_type[1]}, 32'd3);
        @(negedge clk);
        chk(busy === 1'b0, "R13", "empty one cycle", 32'(busy), 32'd0);
        chk((n_cnt + s_cnt + i_cnt) == 1, "R13", "empty busy cycles",
            32'(n_cnt + s_cnt + i_cnt), 32'd1);
        chk(strobes == 0, "R13", "empty no strobes", 32'(strobes), 32'd0);
        chk(rf[3] === init_val(3), "R13", "empty no write-back", rf[3], init_val(3));

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #400000;
        tests++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule